// File: doc/BRIEF.md
# Flash Bank Erase Suspend/Resume Controller

This block is a cycle-based behavioural model of the command state machine for one bank of a NOR flash. Bus writes carry a command code, an address and a bank-select qualifier. A sector-erase command opens an acceptance window in which more sectors can be queued. After the window the erase runs for a fixed number of clock cycles, and the clock stands in for real time throughout. Chip erase, byte program and an identification (autoselect) mode are also supported.

The defining feature is the pause of a sector erase. A suspend code stops the erase at once if the acceptance window is still open. If the erase is already running, the suspend takes effect after a configurable number of cycles. While paused, the bank serves array reads of sectors that are not queued for erase. A read of a queued sector returns a status byte. Programs to unqueued sectors and identification reads are also served during the pause. A resume code continues the erase from where it stopped.

Reads are combinational from the read address and the current mode. A ready output reports whether an erase or program is active. The array is a small register file.

Top module: `flash_bank_ctl`

## Requirements
- R1: An active-low `rst_n` at any time returns the bank to array-read mode with `ready` high, drops every queued sector and leaves the array contents unchanged.
- R2: Write 20h in array-read mode to queue the sector at `wr_addr[AW-1:AW-SB]` and open a window of WIN_CYC cycles. Each further 20h write during the window queues another sector and restarts the window. The erase then runs for ERASE_CYC cycles. Afterwards, every location of a queued sector reads FFh and the bank is back in array-read mode.
- R3: While an erase window, erase, suspend transition or program is active, `ready` is low and every read returns status. The status byte is 08h during the window and 00h otherwise.
- R4: B0h written during the acceptance window enters erase-suspend-read mode in the next cycle.
- R5: B0h written while the erase runs gives SUSP_CYC busy cycles, then erase-suspend-read mode. No erase progress is made while suspending or suspended.
- R6: While an erase runs, every write other than B0h is ignored. B0h is ignored during a chip erase or a program.
- R7: In erase-suspend-read mode `ready` is high. Reads of unqueued sectors return array data, and reads of queued sectors return status 80h.
- R8: In erase-suspend-read mode, A0h followed by a data write to an unqueued sector programs that byte in PROG_CYC busy cycles and returns to erase-suspend-read. A data write to a queued sector is dropped and returns to erase-suspend-read at once.
- R9: 90h enters identification mode from array-read or erase-suspend-read. In this mode reads return ID_MFR when `rd_addr[0]` is 0 and ID_DEV when it is 1, at any address. F0h returns to the mode that was left.
- R10: 30h in erase-suspend-read mode restarts the erase with its remaining cycle count. Further 30h writes are ignored, and a new B0h is accepted.
- R11: A write with `wr_bank` low has no effect in any mode.
- R12: 10h in array-read mode erases every location to FFh in ERASE_CYC busy cycles.
- R13: A0h followed by a data write in array-read mode stores the byte after PROG_CYC busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock; its cycles model time |
| rst_n | input | 1 | asynchronous hardware reset, active low |
| wr_en | input | 1 | bus write strobe, one cycle per write |
| wr_bank | input | 1 | write addresses this bank |
| wr_addr | input | AW | write address |
| wr_data | input | 8 | command code or program data |
| rd_addr | input | AW | read address |
| rd_data | output | 8 | array data, status or identification code |
| ready | output | 1 | high in every read mode, low while busy |

## Verification
A write is sampled on a rising edge, and its effect on `ready` and `rd_data` shows after that edge: the new mode is visible one cycle after the write. A timed phase of N cycles keeps `ready` low for exactly N cycles from that point, and its final memory update is readable on the cycle after the last busy one. The bench drives inputs just after each rising edge. It advances a behavioural reference model on the same edge and compares both outputs at the falling edge of every cycle, so each cycle-exact deadline is checked where it falls.

// File: rtl/flash_bank_ctl.sv
`timescale 1ns/1ps
module flash_bank_ctl #(
  parameter int AW        = 6,
  parameter int SB        = 2,
  parameter int WIN_CYC   = 8,
  parameter int ERASE_CYC = 24,
  parameter int SUSP_CYC  = 3,
  parameter int PROG_CYC  = 4,
  parameter logic [7:0] ID_MFR = 8'h5A,
  parameter logic [7:0] ID_DEV = 8'hC3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          ready
);
  localparam int NSEC  = 1 << SB;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(ERASE_CYC + WIN_CYC + SUSP_CYC + PROG_CYC + 1);

  localparam logic [3:0] S_RD = 4'd0, S_AS = 4'd1, S_PSET = 4'd2, S_PRG = 4'd3,
                         S_WIN = 4'd4, S_ERS = 4'd5, S_SPND = 4'd6, S_SRD = 4'd7,
                         S_SPSET = 4'd8, S_SPRG = 4'd9, S_SAS = 4'd10, S_CHIP = 4'd11;

  localparam logic [7:0] C_PROG = 8'hA0, C_SER = 8'h20, C_CHIP = 8'h10, C_ID = 8'h90,
                         C_EXIT = 8'hF0, C_SUSP = 8'hB0, C_RES = 8'h30;

  logic [3:0]      st;
  logic [CW-1:0]   tmr, erl;
  logic [NSEC-1:0] mark;
  logic [AW-1:0]   pa;
  logic [7:0]      pd;
  logic [7:0]      mem [DEPTH];

  wire          cmd  = wr_en & wr_bank;
  wire [SB-1:0] wsec = wr_addr[AW-1 -: SB];
  wire [SB-1:0] rsec = rd_addr[AW-1 -: SB];
  wire          susp = cmd && wr_data == C_SUSP;
  wire          prg_done = (st == S_PRG || st == S_SPRG) && tmr == '0;
  wire          ers_done = st == S_ERS && !susp && erl == '0;
  wire          chp_done = st == S_CHIP && erl == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RD; tmr <= '0; erl <= '0; mark <= '0; pa <= '0; pd <= '0;
    end else begin
      case (st)
        S_RD: if (cmd) begin
          case (wr_data)
            C_PROG: st <= S_PSET;
            C_SER:  begin
              st <= S_WIN; mark <= mark | (NSEC'(1) << wsec);
              tmr <= CW'(WIN_CYC - 1); erl <= CW'(ERASE_CYC - 1);
            end
            C_CHIP: begin st <= S_CHIP; erl <= CW'(ERASE_CYC - 1); end
            C_ID:   st <= S_AS;
            default: ;
          endcase
        end
        S_AS:  if (cmd && wr_data == C_EXIT) st <= S_RD;
        S_SAS: if (cmd && wr_data == C_EXIT) st <= S_SRD;
        S_PSET: if (cmd) begin
          pa <= wr_addr; pd <= wr_data; tmr <= CW'(PROG_CYC - 1); st <= S_PRG;
        end
        S_PRG:  if (tmr == '0) st <= S_RD;  else tmr <= tmr - 1'b1;
        S_SPRG: if (tmr == '0) st <= S_SRD; else tmr <= tmr - 1'b1;
        S_WIN: begin
          if (susp) st <= S_SRD;
          else if (cmd && wr_data == C_SER) begin
            mark <= mark | (NSEC'(1) << wsec); tmr <= CW'(WIN_CYC - 1);
          end else if (tmr == '0) st <= S_ERS;
          else tmr <= tmr - 1'b1;
        end
        S_ERS: begin
          if (susp) begin st <= S_SPND; tmr <= CW'(SUSP_CYC - 1); end
          else if (erl == '0) begin st <= S_RD; mark <= '0; end
          else erl <= erl - 1'b1;
        end
        S_SPND: if (tmr == '0) st <= S_SRD; else tmr <= tmr - 1'b1;
        S_SRD: if (cmd) begin
          case (wr_data)
            C_RES:  st <= S_ERS;
            C_PROG: st <= S_SPSET;
            C_ID:   st <= S_SAS;
            default: ;
          endcase
        end
        S_SPSET: if (cmd) begin
          if (mark[wsec]) st <= S_SRD;
          else begin
            pa <= wr_addr; pd <= wr_data; tmr <= CW'(PROG_CYC - 1); st <= S_SPRG;
          end
        end
        S_CHIP: if (erl == '0) st <= S_RD; else erl <= erl - 1'b1;
        default: st <= S_RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (prg_done) mem[pa] <= pd;
      for (int i = 0; i < DEPTH; i++)
        if (chp_done || (ers_done && mark[i >> (AW - SB)])) mem[i] <= 8'hFF;
    end
  end

  always_comb begin
    case (st)
      S_AS, S_SAS:    rd_data = rd_addr[0] ? ID_DEV : ID_MFR;
      S_RD, S_PSET:   rd_data = mem[rd_addr];
      S_SRD, S_SPSET: rd_data = mark[rsec] ? 8'h80 : mem[rd_addr];
      S_WIN:          rd_data = 8'h08;
      default:        rd_data = 8'h00;
    endcase
  end

  assign ready = st == S_RD || st == S_AS || st == S_PSET ||
                 st == S_SRD || st == S_SPSET || st == S_SAS;
endmodule

// File: rtl/flash_bank_chk.sv
`timescale 1ns/1ps
module flash_bank_chk #(
  parameter int CW = 6,
  parameter int SUSP_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_bank,
  input logic [7:0]    wr_data,
  input logic [3:0]    st,
  input logic [CW-1:0] erl,
  input logic [7:0]    rd_data,
  input logic          ready
);
  wire wcmd = wr_en & wr_bank;
  logic [CW:0] spnd_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) spnd_cnt <= '0;
    else if (st == 4'd6) spnd_cnt <= spnd_cnt + 1'b1;
    else spnd_cnt <= '0;

  assert_win_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd4 && wcmd && wr_data == 8'hB0) |=> st == 4'd7);

  assert_erase_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd5 && !(wcmd && wr_data == 8'hB0) && erl != '0)
      |=> (st == 4'd5 && erl == $past(erl) - 1'b1));

  assert_chip_no_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd11 && erl != '0) |=> st == 4'd11);

  assert_resume_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd7 && wcmd && wr_data == 8'h30) |=> (st == 4'd5 && erl == $past(erl)));

  assert_suspend_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 4'd6) |-> spnd_cnt < (CW+1)'(SUSP_CYC));

  assert_busy_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (rd_data == 8'h00 || rd_data == 8'h08));
endmodule

bind flash_bank_ctl flash_bank_chk #(.CW(CW), .SUSP_CYC(SUSP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_data(wr_data),
  .st(st), .erl(erl), .rd_data(rd_data), .ready(ready));

// File: tb/sim_flash_bank_ctl.sv
`timescale 1ns/1ps
module sim_flash_bank_ctl;
  localparam int AW = 6, SB = 2, WIN = 8, ERS = 24, SUS = 3, PRG = 4;
  localparam int DEPTH = 1 << AW;
  localparam int M_RD = 0, M_ID = 1, M_PS = 2, M_PG = 3, M_WN = 4, M_ER = 5,
                 M_SP = 6, M_SR = 7, M_SPS = 8, M_SPG = 9, M_SID = 10, M_CH = 11;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_bank = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ready;

  flash_bank_ctl #(.AW(AW), .SB(SB), .WIN_CYC(WIN), .ERASE_CYC(ERS),
                   .SUSP_CYC(SUS), .PROG_CYC(PRG)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready));

  always #2.5 clk = ~clk;

  int md, cnt, left, pa, pd, vectors, fails;
  bit queued [4];
  int mem [DEPTH];
  string req = "R1";
  bit done = 0;

  function automatic int sec_of(int a); return a >> (AW - SB); endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      md = M_RD; cnt = 0; left = 0;
      foreach (queued[i]) queued[i] = 0;
    end else begin
      bit c; int d;
      c = wr_en && wr_bank; d = int'(wr_data);
      case (md)
        M_RD: if (c) begin
          if (d == 'hA0) md = M_PS;
          else if (d == 'h20) begin md = M_WN; queued[sec_of(wr_addr)] = 1; cnt = WIN; left = ERS; end
          else if (d == 'h10) begin md = M_CH; left = ERS; end
          else if (d == 'h90) md = M_ID;
        end
        M_ID:  if (c && d == 'hF0) md = M_RD;
        M_SID: if (c && d == 'hF0) md = M_SR;
        M_PS:  if (c) begin pa = wr_addr; pd = d; cnt = PRG; md = M_PG; end
        M_PG, M_SPG: begin
          cnt--;
          if (cnt == 0) begin mem[pa] = pd; md = (md == M_PG) ? M_RD : M_SR; end
        end
        M_WN: begin
          if (c && d == 'hB0) md = M_SR;
          else if (c && d == 'h20) begin queued[sec_of(wr_addr)] = 1; cnt = WIN; end
          else begin cnt--; if (cnt == 0) md = M_ER; end
        end
        M_ER: begin
          if (c && d == 'hB0) begin md = M_SP; cnt = SUS; end
          else begin
            left--;
            if (left == 0) begin
              for (int a = 0; a < DEPTH; a++) if (queued[sec_of(a)]) mem[a] = 'hFF;
              foreach (queued[i]) queued[i] = 0;
              md = M_RD;
            end
          end
        end
        M_SP: begin cnt--; if (cnt == 0) md = M_SR; end
        M_SR: if (c) begin
          if (d == 'h30) md = M_ER;
          else if (d == 'hA0) md = M_SPS;
          else if (d == 'h90) md = M_SID;
        end
        M_SPS: if (c) begin
          if (queued[sec_of(wr_addr)]) md = M_SR;
          else begin pa = wr_addr; pd = d; cnt = PRG; md = M_SPG; end
        end
        M_CH: begin
          left--;
          if (left == 0) begin for (int a = 0; a < DEPTH; a++) mem[a] = 'hFF; md = M_RD; end
        end
        default: ;
      endcase
    end
  end

  function automatic int exp_rd(int a);
    case (md)
      M_ID, M_SID: return (a % 2) ? 'hC3 : 'h5A;
      M_RD, M_PS:  return mem[a];
      M_SR, M_SPS: return queued[sec_of(a)] ? 'h80 : mem[a];
      M_WN:        return 'h08;
      default:     return 'h00;
    endcase
  endfunction

  function automatic bit exp_ready();
    return md == M_RD || md == M_ID || md == M_PS || md == M_SR || md == M_SPS || md == M_SID;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    int e;
    vectors++;
    e = exp_rd(int'(rd_addr));
    if (ready !== exp_ready()) begin
      fails++;
      $display("FAIL %s: ready=%b expected %b (t=%0t)", req, ready, exp_ready(), $time);
    end else if (e >= 0 && rd_data !== e[7:0]) begin
      fails++;
      $display("FAIL %s: rd_data[%0d]=%h expected %h (t=%0t)", req, rd_addr, rd_data, e[7:0], $time);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    rd_addr = rd_addr + AW'(13);
  endtask

  task automatic idle(int n);
    wr_en = 0;
    repeat (n) tick();
  endtask

  task automatic wr(int a, int d, bit bank = 1);
    wr_en = 1; wr_bank = bank; wr_addr = AW'(a); wr_data = 8'(d);
    tick();
    wr_en = 0; wr_bank = 0;
  endtask

  initial begin
    foreach (mem[i]) mem[i] = -1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    req = "R1"; idle(3);
    req = "R12"; wr(0, 'h10); idle(ERS + 3);
    req = "R13"; wr(0, 'hA0); wr(5, 'h3C); idle(2);
    req = "R6"; wr(0, 'hB0); idle(PRG + 1);
    req = "R13"; wr(0, 'hA0); wr('h15, 'h11); idle(PRG + 1);
    wr(0, 'hA0); wr('h25, 'h22); idle(PRG + 1);
    wr(0, 'hA0); wr('h35, 'h33); idle(PRG + 1);
    req = "R11"; wr('h10, 'h20, 0); wr(0, 'h90, 0); idle(3);
    req = "R2"; wr('h10, 'h20); idle(2); wr('h20, 'h20); idle(3);
    req = "R4"; wr(0, 'hB0);
    req = "R7"; idle(8);
    req = "R9"; wr('h12, 'h90); idle(4); wr(0, 'hF0); idle(3);
    req = "R8"; wr(0, 'hA0); wr('h06, 'h5A); idle(PRG + 2);
    wr(0, 'hA0); wr('h12, 'h00); idle(3);
    req = "R10"; wr(0, 'h30); wr(0, 'h30); idle(5);
    req = "R5"; wr(0, 'hB0); idle(SUS + 4);
    req = "R10"; wr(0, 'h30); idle(3);
    req = "R2"; idle(ERS + 3);
    req = "R6"; wr('h30, 'h20); idle(WIN + 2);
    wr(0, 'hA0); wr(1, 'h10); wr(2, 'h90); wr(3, 'h20); idle(ERS + 2);
    req = "R1"; wr(0, 'hA0); wr(1, 'h77); idle(PRG + 1);
    wr(0, 'h20); idle(WIN + 3);
    #1 rst_n = 0; @(posedge clk); #1 rst_n = 1;
    idle(6);
    req = "R12"; wr(0, 'h10); idle(3); wr(0, 'hB0); idle(ERS + 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule